// File: doc/BRIEF.md
# Read-only serial EEPROM slave (two-wire, strobe driven)

This block models the slave side of a two-wire serial EEPROM holding 256 bytes of fixed contents. A bit-banging master does not share a bus clock with it. Instead, the master presents new SCL and SDA levels and pulses a one-cycle update strobe. On each strobe the block compares the new levels with the stored ones and classifies the event: a start, a stop, a rising SCL edge or nothing of interest. It then returns the SDA level it wants the master to read back.

A transfer opens with a start condition. The master then clocks in a control byte, most significant bit first. Bit 0 of that byte selects read mode. The block acknowledges by pulling SDA low on the next rising SCL edge. Next the master clocks in an 8-bit word address. While it does so in read mode, the block returns the data register one bit per edge, most significant bit first. After the eighth address bit the block loads the data register from the addressed byte and acknowledges again. It then falls back to idle.

The phase register has three states:
- `PH_IDLE` waits for a start.
- `PH_CTRL` collects the control byte.
- `PH_WORD` collects the address.

The phase moves as follows:
- A start moves any phase to `PH_CTRL`.
- The eighth control bit moves `PH_CTRL` to `PH_WORD` and raises the acknowledge flag.
- The eighth address bit moves `PH_WORD` to `PH_IDLE`, loads data and raises the acknowledge flag.

Top module: `i2c_rom_slave`

## Requirements
- R1: After reset, sda_out is 1 and the block is idle. Without an update strobe, neither sda_out nor the phase changes.
- R2: SCL held high across an update while SDA falls from 1 to 0 is a start. From any phase it clears the control register and begins a new control byte. SDA rising while SCL is held high is a stop. A stop only updates the stored SDA level, so sda_out reads 1 after it.
- R3: While idle with no acknowledge pending, SCL activity is ignored. No acknowledge ever appears, and sda_out simply echoes the last sda_in.
- R4: A bit is accepted only on a rising SCL edge where SDA equals its stored level. A rising edge that also changes SDA is ignored and does not count.
- R5: The control byte is eight accepted bits, MSB first. On the rising SCL edge that follows the eighth bit, sda_out is driven 0 (acknowledge), and the pending flag is cleared.
- R6: With control bit 0 = 0 (write mode), sda_out echoes the master's SDA level during the control and address bits.
- R7: With control bit 0 = 1 (read mode), each accepted address bit returns the data register's MSB on sda_out. The data register shifts left one place on every accepted address bit, in either mode.
- R8: After the eighth address bit, the data register is loaded from the byte at that address. The next rising SCL edge returns 0 as acknowledge, and the block is then idle.
- R9: The byte contents are fixed: address 0x00 = 0x80, 0x01 = 0x08, 0x02 = 0x04, and every other address = 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd | input | 1 | One-cycle strobe: scl_in/sda_in carry new line levels |
| scl_in | input | 1 | SCL level written by the master |
| sda_in | input | 1 | SDA level written by the master |
| sda_out | output | 1 | SDA level returned to the master (registered) |

## Verification
Every result is held in a register that loads on the clock edge where `upd` is high. The line value or acknowledge a strobe produces is therefore visible on `sda_out` one clock after the strobe, and it stays put until the next strobe. The bench raises `upd` at a falling edge, drops it at the next falling edge and samples `sda_out` at that same moment, so each sample reflects exactly one update. Read data fetched by one transfer is observed during the address bits of the following read transfer. This is why the expected bytes, including the four-place shift left by an aborted address, are computed across transfer pairs.

// File: rtl/i2c_rom_pkg.sv
package i2c_rom_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CTRL = 2'd1,
        PH_WORD = 2'd2
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic steady;
    } line_ev_t;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events
    import i2c_rom_pkg::*;
(
    input  logic     scl_prev,
    input  logic     sda_prev,
    input  logic     scl_now,
    input  logic     sda_now,
    output line_ev_t ev
);
    logic scl_held;

    assign scl_held  = scl_prev & scl_now;
    assign ev.start  = scl_held &  sda_prev & ~sda_now;
    assign ev.stop   = scl_held & ~sda_prev &  sda_now;
    assign ev.rise   = ~scl_prev & scl_now;
    assign ev.steady = (sda_prev == sda_now);
endmodule

// File: rtl/i2c_preset_rom.sv
module i2c_preset_rom #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] q
);
    always_comb begin
        case (addr)
            AW'(0):  q = DW'(8'h80);
            AW'(1):  q = DW'(8'h08);
            AW'(2):  q = DW'(8'h04);
            default: q = '0;
        endcase
    end
endmodule

// File: rtl/i2c_rom_ctrl.sv
module i2c_rom_ctrl
    import i2c_rom_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int CNT_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          scl_in,
    input  logic          sda_in,
    input  line_ev_t      ev,
    input  logic [DW-1:0] rom_q,
    output logic [AW-1:0] rom_addr,
    output logic          scl_q,
    output logic          sda_q,
    output phase_e        phase,
    output logic          ack_pend
);
    localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CW - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(AW - 1);

    phase_e           phase_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CW-1:0]    cmd, cmd_n;
    logic [AW-1:0]    addr, addr_n;
    logic [DW-1:0]    data, data_n;
    logic             ack_n, sda_n;
    logic             is_read;

    assign is_read  = cmd[0];
    assign rom_addr = {addr[AW-2:0], sda_in};

    // next-state process
    always_comb begin
        phase_n = phase;
        cnt_n   = cnt;
        cmd_n   = cmd;
        addr_n  = addr;
        data_n  = data;
        ack_n   = ack_pend;
        sda_n   = sda_in;
        if (ev.start) begin
            phase_n = PH_CTRL;
            cnt_n   = '0;
            cmd_n   = '0;
        end else if (ev.stop) begin
            // only the stored level follows
        end else if (phase == PH_IDLE && !ack_pend) begin
            // waiting for a start
        end else if (ev.rise) begin
            if (ack_pend) begin
                sda_n = 1'b0;
                ack_n = 1'b0;
            end else if (ev.steady) begin
                unique case (phase)
                    PH_CTRL: begin
                        cmd_n = {cmd[CW-2:0], sda_in};
                        cnt_n = cnt + CNT_W'(1);
                        if (cnt == CTRL_LAST) begin
                            phase_n = PH_WORD;
                            cnt_n   = '0;
                            ack_n   = 1'b1;
                        end
                    end
                    PH_WORD: begin
                        if (is_read)
                            sda_n = data[DW-1];
                        addr_n = rom_addr;
                        data_n = data << 1;
                        cnt_n  = cnt + CNT_W'(1);
                        if (cnt == WORD_LAST) begin
                            data_n  = rom_q;
                            ack_n   = 1'b1;
                            phase_n = PH_IDLE;
                            cnt_n   = '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            cmd      <= '0;
            addr     <= '0;
            data     <= '0;
            ack_pend <= 1'b0;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else if (upd) begin
            phase    <= phase_n;
            cnt      <= cnt_n;
            cmd      <= cmd_n;
            addr     <= addr_n;
            data     <= data_n;
            ack_pend <= ack_n;
            scl_q    <= scl_in;
            sda_q    <= sda_n;
        end
    end
endmodule

// File: rtl/i2c_rom_slave.sv
module i2c_rom_slave
    import i2c_rom_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);
    localparam int LEN   = (CW > AW) ? CW : AW;
    localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;

    line_ev_t      ev;
    logic          scl_q, sda_q, ack_pend;
    phase_e        phase;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_q;

    i2c_line_events u_ev (
        .scl_prev (scl_q),
        .sda_prev (sda_q),
        .scl_now  (scl_in),
        .sda_now  (sda_in),
        .ev       (ev)
    );

    i2c_preset_rom #(.AW(AW), .DW(DW)) u_rom (
        .addr (rom_addr),
        .q    (rom_q)
    );

    i2c_rom_ctrl #(.AW(AW), .DW(DW), .CW(CW), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .ev       (ev),
        .rom_q    (rom_q),
        .rom_addr (rom_addr),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .phase    (phase),
        .ack_pend (ack_pend)
    );

    assign sda_out = sda_q;
endmodule

// File: rtl/i2c_rom_slave_chk.sv
module i2c_rom_slave_chk
    import i2c_rom_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   upd,
    input logic   scl_in,
    input logic   sda_in,
    input logic   sda_out,
    input logic   scl_q,
    input phase_e phase,
    input logic   ack_pend
);
    logic start_seen;
    assign start_seen = scl_q & scl_in & sda_out & ~sda_in;

    // R1
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(sda_out) && $stable(phase));

    // R2
    start_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && start_seen |=> phase == PH_CTRL);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && phase == PH_IDLE && !ack_pend && !start_seen
        |=> phase == PH_IDLE && !ack_pend && sda_out == $past(sda_in));

    // R4
    glitch_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && !ack_pend && phase != PH_IDLE && !scl_q && scl_in && (sda_out != sda_in)
        |=> $stable(phase) && !ack_pend);

    // R5
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && ack_pend && !scl_q && scl_in |=> !sda_out && !ack_pend);
endmodule

bind i2c_rom_slave i2c_rom_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_out  (sda_out),
    .scl_q    (scl_q),
    .phase    (phase),
    .ack_pend (ack_pend)
);

// File: tb/tb_i2c_rom_slave.sv
`timescale 1ns/1ps
module tb_i2c_rom_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;
    int   total = 0;
    int   bad = 0;

    always #2 clk = ~clk;

    i2c_rom_slave dut (
        .clk(clk), .rst_n(rst_n), .upd(upd),
        .scl_in(scl_in), .sda_in(sda_in), .sda_out(sda_out)
    );

    // {word address, expected byte}
    localparam logic [15:0] VEC [6] = '{16'h0080, 16'h0108, 16'h0204,
                                        16'h7F00, 16'hC300, 16'h0300};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic d);
        @(negedge clk);
        scl_in = c; sda_in = d; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic do_start();
        step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
        chk("R2 start level", {7'd0, sda_out}, 8'h00);
    endtask

    task automatic do_stop();
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
        chk("R2 stop level", {7'd0, sda_out}, 8'h01);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, b[i]); step(1'b1, b[i]);
            got[i] = sda_out;
        end
    endtask

    task automatic ack_clk(input string tag);
        step(1'b0, 1'b1); step(1'b1, 1'b1);
        chk(tag, {7'd0, sda_out}, 8'h00);
    endtask

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset sda_out", {7'd0, sda_out}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        scl_in = 1'b0; sda_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 no strobe", {7'd0, sda_out}, 8'h01);

        // R3: clocks while idle give no acknowledge, SDA echoes
        for (int i = 0; i < 9; i++) begin
            step(1'b0, 1'b1); step(1'b1, 1'b1);
            chk("R3 idle no ack", {7'd0, sda_out}, 8'h01);
        end
        step(1'b0, 1'b0); step(1'b1, 1'b0);
        chk("R3 idle echo", {7'd0, sda_out}, 8'h00);
        step(1'b1, 1'b1);

        // vector table: write address, then read back through the next transfer
        foreach (VEC[k]) begin
            do_start();
            send_byte(8'hA0, got);
            chk("R6 ctrl echo", got, 8'hA0);
            ack_clk("R5 ctrl ack");
            send_byte(VEC[k][15:8], got);
            chk("R6 addr echo", got, VEC[k][15:8]);
            ack_clk("R8 addr ack");
            do_stop();
            do_start();
            send_byte(8'hA1, got);
            ack_clk("R5 read ctrl ack");
            send_byte(8'hFF, got);
            chk("R7 R9 read data", got, VEC[k][7:0]);
            ack_clk("R8 read ack");
            do_stop();
        end

        // R4: a rising edge that changes SDA is not a bit
        do_start();
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, 1'(8'hA1 >> i)); step(1'b1, 1'(8'hA1 >> i));
            if (i == 4) begin
                step(1'b0, 1'b0); step(1'b1, 1'b1);
            end
        end
        chk("R4 no early ack", {7'd0, sda_out}, 8'h01);
        ack_clk("R4 ack after eight bits");
        send_byte(8'hFF, got);
        chk("R4 read after glitch", got, 8'h00);
        ack_clk("R8 ack after glitch read");
        do_stop();

        // R2 + R7: restart in the address phase; data shifts in write mode too
        do_start();
        send_byte(8'hA0, got);
        ack_clk("R5 ack before restart");
        send_byte(8'h01, got);
        ack_clk("R8 load 0x01");
        do_stop();
        do_start();
        send_byte(8'hA0, got);
        ack_clk("R5 ack restart ctrl");
        for (int i = 0; i < 4; i++) begin
            step(1'b0, (i != 1)); step(1'b1, (i != 1));
        end
        step(1'b1, 1'b0);   // start while SCL high
        send_byte(8'hA1, got);
        ack_clk("R2 restart ctrl ack");
        send_byte(8'hFF, got);
        chk("R7 shifted data", got, 8'h80);
        ack_clk("R8 final ack");
        do_stop();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule